// File: doc/BRIEF.md
# Call Frame Push/Pop Sequencer

This block performs the memory side of subroutine entry and exit for a 32-bit processor. It talks to a word-wide memory port that has a request, a write enable, an address, write data, read data and a ready signal. The core gives it a call command with the branch target, the address of the calling instruction, the instruction form, and the current frame and stack pointers. The block then builds the frame in memory and hands back the new frame pointer, stack pointer and program counter.

Every frame has three words below the caller's stack pointer. From the top down they are a reserved word that is never written, the link (return) address, and the saved frame pointer. A return command unwinds from the frame pointer, not from the stack pointer. It reads the saved frame pointer and the link address back, and it places the stack pointer just above the reserved word. Instruction fetch and the register file are outside the block. All pointers enter and leave through ports.

Top module: `frame_seq`

## Requirements
- R1: During and straight after reset, busy, done and mem_req are low and fp_out, sp_out and pc_out read zero.
- R2: An accepted call first writes to address sp_in-8. The word at sp_in-4 is left untouched, and no access of any kind is made to it.
- R3: The word stored at sp_in-8 is insn_addr+6 when call_reg_form is 0 (absolute-target form) and insn_addr+2 when call_reg_form is 1 (register-target form).
- R4: The second and last write of a call stores fp_in at address sp_in-12.
- R5: When a call completes, fp_out and sp_out both equal sp_in-12 and pc_out equals call_target. done is high for exactly one cycle.
- R6: An accepted return makes exactly two reads: first the word at fp_in, then the word at fp_in+4.
- R7: When a return completes, fp_out holds the word read from fp_in, pc_out holds the word read from fp_in+4, and sp_out equals fp_in+12. All address arithmetic wraps modulo 2^32.
- R8: An access holds mem_req, mem_addr, mem_we and mem_wdata steady until mem_ready is sampled high. Only then does the next access begin.
- R9: busy is high from the cycle after a command is accepted until the sequence ends. Commands and pointer inputs presented while busy is high have no effect, and the result outputs stay unchanged while busy.
- R10: If cmd_call and cmd_ret are both high while the block is idle, the call is performed.
- R11: done rises in the cycle after the final access completes, never while busy is high. A command presented in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_call | input | 1 | Start a call sequence (sampled when idle) |
| cmd_ret | input | 1 | Start a return sequence (sampled when idle) |
| call_reg_form | input | 1 | 1: register-target call (link +2); 0: absolute-target call (link +6) |
| call_target | input | 32 | Address the call jumps to |
| insn_addr | input | 32 | Address of the call instruction |
| fp_in | input | 32 | Current frame pointer |
| sp_in | input | 32 | Current stack pointer |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence has finished |
| fp_out | output | 32 | Resulting frame pointer |
| sp_out | output | 32 | Resulting stack pointer |
| pc_out | output | 32 | Resulting program counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |

## Verification
A wrong state register or latched context shows at the memory port within one access. The bench sees a wrong address, a wrong direction, a write to the reserved word, or a third access, and it logs every access per sequence. A fault in the result path stays hidden until done, and then shows as a wrong pointer or program counter. A fault in command gating shows as results that follow the garbage commands injected while busy. Random ready latencies and wrap-around pointers make an offset or hold error visible in the sequence where it happens.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int XLEN       = 32;
  localparam int WORD_BYTES = 4;
  localparam int LINK_LONG  = 6;
  localparam int LINK_SHORT = 2;
  localparam int FRAME_WORDS = 3;
  localparam logic [XLEN-1:0] WORD_STEP  = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] FRAME_SPAN = XLEN'(WORD_BYTES * FRAME_WORDS);

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CALL_RA = 3'd1,
    ST_CALL_FP = 3'd2,
    ST_RET_FP  = 3'd3,
    ST_RET_RA  = 3'd4
  } fseq_state_e;

  // Link address saved by a call, chosen by instruction form.
  function automatic word_t link_of(input word_t insn, input logic reg_form);
    return insn + (reg_form ? XLEN'(LINK_SHORT) : XLEN'(LINK_LONG));
  endfunction

  // Stack pointer after the whole frame has been pushed.
  function automatic word_t frame_floor(input word_t sp);
    return sp - FRAME_SPAN;
  endfunction

  // Slot holding the link address (below the reserved word).
  function automatic word_t link_slot(input word_t sp);
    return sp - (WORD_STEP + WORD_STEP);
  endfunction

  // Stack pointer restored on return.
  function automatic word_t unwind_sp(input word_t fp);
    return fp + FRAME_SPAN;
  endfunction
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_call,
  input  logic        cmd_ret,
  input  logic        mem_ready,
  output fseq_state_e state,
  output logic        accept_call,
  output logic        accept_ret,
  output logic        seq_last,
  output logic        busy
);
  fseq_state_e state_nxt;

  assign busy        = (state != ST_IDLE);
  assign accept_call = !busy && cmd_call;
  assign accept_ret  = !busy && !cmd_call && cmd_ret;
  assign seq_last    = mem_ready && ((state == ST_CALL_FP) || (state == ST_RET_RA));

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (accept_call)     state_nxt = ST_CALL_RA;
        else if (accept_ret) state_nxt = ST_RET_FP;
      end
      ST_CALL_RA: if (mem_ready) state_nxt = ST_CALL_FP;
      ST_CALL_FP: if (mem_ready) state_nxt = ST_IDLE;
      ST_RET_FP:  if (mem_ready) state_nxt = ST_RET_RA;
      ST_RET_RA:  if (mem_ready) state_nxt = ST_IDLE;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/fseq_ctx.sv
module fseq_ctx
  import fseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  fseq_state_e state,
  input  logic        accept_call,
  input  logic        accept_ret,
  input  logic        mem_ready,
  input  word_t       call_target,
  input  word_t       insn_addr,
  input  logic        call_reg_form,
  input  word_t       fp_in,
  input  word_t       sp_in,
  input  word_t       mem_rdata,
  output word_t       ctx_base,
  output word_t       ctx_target,
  output word_t       restored_fp,
  output logic        mem_we,
  output word_t       mem_addr,
  output word_t       mem_wdata
);
  word_t ctx_link;
  word_t ctx_old_fp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_base    <= '0;
      ctx_target  <= '0;
      ctx_link    <= '0;
      ctx_old_fp  <= '0;
      restored_fp <= '0;
    end else begin
      if (accept_call) begin
        ctx_base   <= sp_in;
        ctx_target <= call_target;
        ctx_link   <= link_of(insn_addr, call_reg_form);
        ctx_old_fp <= fp_in;
      end else if (accept_ret) begin
        ctx_base <= fp_in;
      end
      if (state == ST_RET_FP && mem_ready) restored_fp <= mem_rdata;
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_CALL_RA: begin
        mem_we    = 1'b1;
        mem_addr  = link_slot(ctx_base);
        mem_wdata = ctx_link;
      end
      ST_CALL_FP: begin
        mem_we    = 1'b1;
        mem_addr  = frame_floor(ctx_base);
        mem_wdata = ctx_old_fp;
      end
      ST_RET_FP: mem_addr = ctx_base;
      ST_RET_RA: mem_addr = ctx_base + WORD_STEP;
      default: ;
    endcase
  end
endmodule

// File: rtl/fseq_result.sv
module fseq_result
  import fseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  fseq_state_e state,
  input  logic        seq_last,
  input  word_t       ctx_base,
  input  word_t       ctx_target,
  input  word_t       restored_fp,
  input  word_t       mem_rdata,
  output logic        done,
  output word_t       fp_out,
  output word_t       sp_out,
  output word_t       pc_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      fp_out <= '0;
      sp_out <= '0;
      pc_out <= '0;
    end else begin
      done <= seq_last;
      if (seq_last) begin
        if (state == ST_CALL_FP) begin
          fp_out <= frame_floor(ctx_base);
          sp_out <= frame_floor(ctx_base);
          pc_out <= ctx_target;
        end else begin
          fp_out <= restored_fp;
          sp_out <= unwind_sp(ctx_base);
          pc_out <= mem_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import fseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_call,
  input  logic        cmd_ret,
  input  logic        call_reg_form,
  input  logic [31:0] call_target,
  input  logic [31:0] insn_addr,
  input  logic [31:0] fp_in,
  input  logic [31:0] sp_in,
  output logic        busy,
  output logic        done,
  output logic [31:0] fp_out,
  output logic [31:0] sp_out,
  output logic [31:0] pc_out,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready
);
  fseq_state_e state;
  logic  accept_call;
  logic  accept_ret;
  logic  seq_last;
  word_t ctx_base;
  word_t ctx_target;
  word_t restored_fp;

  assign mem_req = busy;

  fseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
    .mem_ready(mem_ready), .state(state), .accept_call(accept_call),
    .accept_ret(accept_ret), .seq_last(seq_last), .busy(busy)
  );

  fseq_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .state(state), .accept_call(accept_call),
    .accept_ret(accept_ret), .mem_ready(mem_ready), .call_target(call_target),
    .insn_addr(insn_addr), .call_reg_form(call_reg_form), .fp_in(fp_in),
    .sp_in(sp_in), .mem_rdata(mem_rdata), .ctx_base(ctx_base),
    .ctx_target(ctx_target), .restored_fp(restored_fp), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  fseq_result u_res (
    .clk(clk), .rst_n(rst_n), .state(state), .seq_last(seq_last),
    .ctx_base(ctx_base), .ctx_target(ctx_target), .restored_fp(restored_fp),
    .mem_rdata(mem_rdata), .done(done), .fp_out(fp_out), .sp_out(sp_out),
    .pc_out(pc_out)
  );
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_call,
  input logic        cmd_ret,
  input logic [31:0] fp_in,
  input logic [31:0] sp_in,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] pc_out,
  input logic [31:0] fp_out,
  input logic        accept_call,
  input logic        accept_ret,
  input logic        seq_last
);
  p_req_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_hold_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_call_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_call |=> mem_req && mem_we && (mem_addr == $past(sp_in) - 32'd8));

  p_ret_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_call && cmd_ret |=> mem_req && !mem_we && (mem_addr == $past(fp_in)));

  p_call_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_call |-> !accept_ret);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_last_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_last |=> done);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_results_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(pc_out) && $stable(fp_out));
endmodule

bind frame_seq fseq_checker u_fseq_chk (
  .clk(clk), .rst_n(rst_n), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
  .fp_in(fp_in), .sp_in(sp_in), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .pc_out(pc_out), .fp_out(fp_out),
  .accept_call(accept_call), .accept_ret(accept_ret), .seq_last(seq_last)
);

// File: tb/frame_seq_test.sv
`timescale 1ns/1ps
module frame_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_call = 1'b0, cmd_ret = 1'b0, call_reg_form = 1'b0;
  logic [31:0] call_target = '0, insn_addr = '0, fp_in = '0, sp_in = '0;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] fp_out, sp_out, pc_out, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  int n_checks = 0;
  int n_errors = 0;

  logic [31:0] log_addr [8];
  logic [31:0] log_data [8];
  logic        log_we   [8];
  int          log_n = 0;
  int          wait_cnt = 0;
  logic [31:0] rd_key = 32'h1357_9bdf;
  bit          inject = 1'b0;

  always #5 clk = ~clk;

  frame_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
    .call_reg_form(call_reg_form), .call_target(call_target),
    .insn_addr(insn_addr), .fp_in(fp_in), .sp_in(sp_in), .busy(busy),
    .done(done), .fp_out(fp_out), .sp_out(sp_out), .pc_out(pc_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [31:0] key);
    return (a * 32'h9E37_79B1) ^ key;
  endfunction

  function automatic logic [31:0] exp_link(input logic [31:0] ia, input logic form);
    return form ? ia + 32'd2 : ia + 32'd6;
  endfunction

  // Memory model: random latency 0..3 cycles, logs every completed access.
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (rst_n && mem_req) begin
      if (wait_cnt == 0) begin
        mem_ready = 1'b1;
        mem_rdata = mem_word(mem_addr, rd_key);
        if (log_n < 8) begin
          log_addr[log_n] = mem_addr;
          log_data[log_n] = mem_wdata;
          log_we[log_n]   = mem_we;
        end
        log_n++;
        wait_cnt = $urandom % 4;
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  // Wait for done; while busy, optionally present garbage commands (R9).
  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) begin
        cmd_call = 1'b0; cmd_ret = 1'b0;
        seen = 1'b1;
        break;
      end
      if (inject && busy) begin
        cmd_call    = ($urandom % 3) == 0;
        cmd_ret     = ($urandom % 2) == 0;
        fp_in       = $urandom; sp_in = $urandom;
        call_target = $urandom; insn_addr = $urandom;
        call_reg_form = $urandom % 2;
      end else begin
        cmd_call = 1'b0; cmd_ret = 1'b0;
      end
    end
  endtask

  task automatic do_call(input logic [31:0] tgt, input logic [31:0] ia, input logic form,
                         input logic [31:0] fp, input logic [31:0] sp, input bit also_ret);
    bit seen;
    @(negedge clk);
    log_n = 0;
    cmd_call = 1'b1; cmd_ret = also_ret;
    call_target = tgt; insn_addr = ia; call_reg_form = form; fp_in = fp; sp_in = sp;
    @(negedge clk);
    cmd_call = 1'b0; cmd_ret = 1'b0;
    chk("R9 busy after call accept", {31'd0, busy}, 32'd1);
    wait_done(seen);
    chk("R11 call done seen", {31'd0, seen}, 32'd1);
    chk("R2 access count (no reserved-slot access)", log_n, 32'd2);
    chk("R2 first write is a write", {31'd0, log_we[0]}, 32'd1);
    chk("R2 link slot address", log_addr[0], sp - 32'd8);
    chk("R3 link value", log_data[0], exp_link(ia, form));
    chk("R4 second write is a write", {31'd0, log_we[1]}, 32'd1);
    chk("R4 saved fp address", log_addr[1], sp - 32'd12);
    chk("R4 saved fp value", log_data[1], fp);
    if (also_ret) chk("R10 call wins", log_addr[0], sp - 32'd8);
    chk("R5 fp_out", fp_out, sp - 32'd12);
    chk("R5 sp_out", sp_out, sp - 32'd12);
    chk("R5 pc_out", pc_out, tgt);
    chk("R11 not busy with done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R5 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic do_ret(input logic [31:0] fp);
    bit seen;
    @(negedge clk);
    log_n = 0;
    rd_key = $urandom;
    cmd_ret = 1'b1; cmd_call = 1'b0; fp_in = fp; sp_in = $urandom;
    @(negedge clk);
    cmd_ret = 1'b0;
    chk("R9 busy after return accept", {31'd0, busy}, 32'd1);
    wait_done(seen);
    chk("R11 return done seen", {31'd0, seen}, 32'd1);
    chk("R6 access count", log_n, 32'd2);
    chk("R6 first read", {log_we[0], log_addr[0][30:0]}, {1'b0, fp[30:0]});
    chk("R6 first read addr", log_addr[0], fp);
    chk("R6 second read", {31'd0, log_we[1]}, 32'd0);
    chk("R6 second read addr", log_addr[1], fp + 32'd4);
    chk("R7 fp_out", fp_out, mem_word(fp, rd_key));
    chk("R7 pc_out", pc_out, mem_word(fp + 32'd4, rd_key));
    chk("R7 sp_out", sp_out, fp + 32'd12);
    @(negedge clk);
    chk("R5 done one cycle after return", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    chk("R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
    chk("R1 pc_out in reset", pc_out, 32'd0);
    chk("R1 fp_out in reset", fp_out, 32'd0);
    chk("R1 sp_out in reset", sp_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, busy, mem_req}, 32'd0);

    // Directed corners
    do_call(32'h0000_1000, 32'h0000_0200, 1'b0, 32'h0000_8000, 32'h0000_9000, 1'b0);
    do_call(32'h0000_2000, 32'h0000_0300, 1'b1, 32'h0000_7000, 32'h0000_0004, 1'b0);
    do_call(32'hDEAD_0000, 32'hFFFF_FFFC, 1'b0, 32'h1234_5678, 32'h0000_0100, 1'b1);
    do_ret(32'h0000_8FF4);
    do_ret(32'hFFFF_FFF8);
    inject = 1'b1;
    do_call(32'hCAFE_0000, 32'h0000_0400, 1'b1, 32'h0000_0040, 32'h0000_0080, 1'b0);
    do_ret(32'h0000_0074);

    // Constrained random mix
    for (int k = 0; k < 60; k++) begin
      inject = ($urandom % 2) == 0;
      if ($urandom % 2)
        do_call($urandom, $urandom, $urandom % 2, $urandom, {$urandom} & 32'hFFFF_FFFC,
                ($urandom % 4) == 0);
      else
        do_ret({$urandom} & 32'hFFFF_FFFC);
    end
    inject = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule